// File: doc/BRIEF.md
# PCI Target Access Policy Filter

This block sits behind the target side of a 32-bit PCI interface. During each address phase it decides which local space the access falls in: configuration, I/O, the register window or the SDRAM window. From that decision and the bus command it sets how the rest of the transaction is served. It drives the target handshake lines and a set of per-phase controls for a backend. Those controls are a write strobe, a read strobe, byte-lane enables, the current word address and an address-advance pulse.

Each space has its own policy. Configuration and I/O accesses get exactly one data phase, and their byte enables select the lanes. Register-window accesses always move a whole 32-bit word, whatever the byte enables say. SDRAM accesses may burst, but only with linearly increasing addresses. A memory access that asks for cacheline-wrap ordering is cut to one data phase. An access that hits no window is never claimed.

The controller is a five-state machine:
- IDLE waits for an address phase.
- DATA claims the bus and completes data phases.
- DISC holds STOP# after a single permitted phase until the initiator drops FRAME#.
- SKIP rides out an unclaimed transaction.
- TURN is a single turnaround cycle in which all target lines are released.

The transitions are:
- IDLE→DATA on a decoded hit.
- IDLE→SKIP on a miss.
- DATA→DATA on a completed phase with more to follow, and on a wait state.
- DATA→DISC when a single-phase access tries to continue.
- DATA→TURN on the final phase.
- DISC→TURN once FRAME# is high.
- SKIP→IDLE once FRAME# and IRDY# are both high.
- TURN→IDLE always.

Top module: `pci_access_filter`

## Requirements
- R1: An address phase is FRAME# low with IRDY# high while idle. When it hits a window with a permitted command, DEVSEL# and TRDY# go low in the following cycle and stay low through the data phases, and `bk_space` reports the space. The space codes are 0 none, 1 config, 2 I/O, 3 register window, 4 SDRAM. The permitted commands are:
  - I/O: 0010 and 0011, window at 0x0000_1000 of 256 bytes.
  - Memory: 0110, 0111, 1100, 1110 and 1111. The register window is at 0x2000_0000 (64 KB). The SDRAM window is at 0x1000_0000 (16 MB).
  - Config: 1010 and 1011, with IDSEL high and AD[1:0]=00.
- R2: A config or I/O access asserts STOP# together with TRDY# in its first data phase. If FRAME# is still low when that phase completes, the next cycle has TRDY# high and STOP# low, held until FRAME# is high. Only one strobe is produced.
- R3: In config and I/O data phases, `bk_be` equals the inverse of C/BE#[3:0].
- R4: In register-window data phases, `bk_be` is 1111 for both reads and writes, independent of C/BE#.
- R5: In an SDRAM burst, `bk_addr` starts at AD[31:2] of the address phase. It rises by one word after each completed phase that is not the last, and `bk_adv` pulses in each such phase. STOP# stays high.
- R6: A memory access whose address phase has AD[1:0]=10 (wrap ordering) is limited to one data phase with the disconnect behaviour of R2.
- R7: `bk_we` or `bk_re` is high only in a cycle where both IRDY# and TRDY# are low. The command bit 0 selects which: 1 means write.
- R8: An access hitting no window, or using any other command, never lowers DEVSEL#, TRDY# or STOP#. It raises no strobe. The block accepts a new address phase once FRAME# and IRDY# are both high.
- R9: After a claimed transaction ends, one cycle follows with DEVSEL#, TRDY# and STOP# all high before a new address phase can be claimed.
- R10: While reset is low, DEVSEL#, TRDY# and STOP# are high and `bk_we`, `bk_re`, `bk_adv` and `bk_be` are zero.
- R11: In SDRAM data phases, `bk_be` equals the inverse of C/BE#[3:0]. Outside a completed phase `bk_be` is 0000.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| frame_n | input | 1 | FRAME#, active low |
| irdy_n | input | 1 | Initiator ready, active low |
| idsel | input | 1 | Configuration select |
| ad | input | 32 | Address/data bus (only the address phase is used) |
| cbe_n | input | 4 | Command in address phase, byte enables in data phases |
| devsel_n | output | 1 | Device select, active low |
| trdy_n | output | 1 | Target ready, active low |
| stop_n | output | 1 | Stop/disconnect request, active low |
| bk_we | output | 1 | Backend write strobe for the completed phase |
| bk_re | output | 1 | Backend read strobe for the completed phase |
| bk_be | output | 4 | Byte lanes applied to the completed phase |
| bk_addr | output | 30 | Current word address |
| bk_adv | output | 1 | Address advances after this phase |
| bk_space | output | 3 | Space code of the claimed access |

## Verification
The checker watches, on every cycle, the handshake rules that hold in any state:
- strobes only with both ready lines low;
- TRDY# only under DEVSEL#;
- exactly one step of the word address per advance pulse;
- a whole word on register-window phases;
- STOP# held without TRDY# after a continued single-phase access;
- the turnaround cycle.

Other behaviours need the bench's scenarios and its cycle-by-cycle model. Those are the choice of space for a given address and command, the claim timing, the cut to one phase for config, I/O and wrap-ordered accesses, lane selection from the live byte enables, wait states inside long back-to-back SDRAM bursts, and silence on misses.

// File: rtl/pci_flt_pkg.sv
package pci_flt_pkg;

    typedef enum logic [2:0] {
        SP_NONE  = 3'd0,
        SP_CFG   = 3'd1,
        SP_IO    = 3'd2,
        SP_MMIO  = 3'd3,
        SP_SDRAM = 3'd4
    } space_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_DATA,
        ST_DISC,
        ST_SKIP,
        ST_TURN
    } state_e;

    typedef struct packed {
        space_e space;
        logic   single;
        logic   write;
    } claim_t;

    localparam claim_t CLAIM_NONE = '{space: SP_NONE, single: 1'b0, write: 1'b0};

    // bus command groups
    function automatic logic cmd_is_io(input logic [3:0] c);
        return c[3:1] == 3'b001;
    endfunction

    function automatic logic cmd_is_cfg(input logic [3:0] c);
        return c[3:1] == 3'b101;
    endfunction

    function automatic logic cmd_is_mem(input logic [3:0] c);
        return (c == 4'b0110) || (c == 4'b0111) || (c == 4'b1100) ||
               (c == 4'b1110) || (c == 4'b1111);
    endfunction

    function automatic logic cmd_is_wr(input logic [3:0] c);
        return (c == 4'b0011) || (c == 4'b0111) || (c == 4'b1011) || (c == 4'b1111);
    endfunction

endpackage

// File: rtl/pci_flt_decode.sv
module pci_flt_decode
    import pci_flt_pkg::*;
#(
    parameter int          ADDR_W     = 32,
    parameter int          BE_W       = 4,
    parameter logic [31:0] SDRAM_BASE = 32'h1000_0000,
    parameter int          SDRAM_LG   = 24,
    parameter logic [31:0] MMIO_BASE  = 32'h2000_0000,
    parameter int          MMIO_LG    = 16,
    parameter logic [31:0] IO_BASE    = 32'h0000_1000,
    parameter int          IO_LG      = 8
) (
    input  logic [ADDR_W-1:0] ad,
    input  logic [BE_W-1:0]   cmd,
    input  logic              idsel,
    output claim_t            claim
);

    function automatic logic win_hit(input logic [ADDR_W-1:0] a,
                                     input logic [ADDR_W-1:0] base,
                                     input int lg);
        return ((a ^ base) >> lg) == '0;
    endfunction

    logic hit_sdram, hit_mmio, hit_io, wrap_req, mem_cmd;

    assign hit_sdram = win_hit(ad, ADDR_W'(SDRAM_BASE), SDRAM_LG);
    assign hit_mmio  = win_hit(ad, ADDR_W'(MMIO_BASE), MMIO_LG);
    assign hit_io    = win_hit(ad, ADDR_W'(IO_BASE), IO_LG);
    assign wrap_req  = (ad[1:0] == 2'b10);
    assign mem_cmd   = cmd_is_mem(cmd);

    always_comb begin
        claim = CLAIM_NONE;
        if (cmd_is_cfg(cmd) && idsel && (ad[1:0] == 2'b00)) begin
            claim.space  = SP_CFG;
            claim.single = 1'b1;
        end else if (cmd_is_io(cmd) && hit_io) begin
            claim.space  = SP_IO;
            claim.single = 1'b1;
        end else if (mem_cmd && hit_mmio) begin
            claim.space  = SP_MMIO;
            claim.single = wrap_req;
        end else if (mem_cmd && hit_sdram) begin
            claim.space  = SP_SDRAM;
            claim.single = wrap_req;
        end
        claim.write = (claim.space != SP_NONE) && cmd_is_wr(cmd);
    end

endmodule

// File: rtl/pci_flt_addr.sv
module pci_flt_addr #(
    parameter int WA_W = 30
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            load,
    input  logic [WA_W-1:0] load_val,
    input  logic            adv,
    output logic [WA_W-1:0] q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '0;
        end else if (load) begin
            q <= load_val;
        end else if (adv) begin
            q <= q + WA_W'(1);
        end
    end

endmodule

// File: rtl/pci_flt_lanes.sv
module pci_flt_lanes
    import pci_flt_pkg::*;
#(
    parameter int BE_W = 4
) (
    input  space_e          space,
    input  logic            active,
    input  logic [BE_W-1:0] cbe_n,
    output logic [BE_W-1:0] be
);

    logic word_only;
    assign word_only = (space == SP_MMIO);

    for (genvar i = 0; i < BE_W; i++) begin : g_lane
        assign be[i] = active & (word_only | ~cbe_n[i]);
    end

endmodule

// File: rtl/pci_access_filter.sv
module pci_access_filter
    import pci_flt_pkg::*;
#(
    parameter int          ADDR_W     = 32,
    parameter int          BE_W       = 4,
    parameter logic [31:0] SDRAM_BASE = 32'h1000_0000,
    parameter int          SDRAM_LG   = 24,
    parameter logic [31:0] MMIO_BASE  = 32'h2000_0000,
    parameter int          MMIO_LG    = 16,
    parameter logic [31:0] IO_BASE    = 32'h0000_1000,
    parameter int          IO_LG      = 8,
    localparam int         WSH        = $clog2(BE_W),
    localparam int         WA_W       = ADDR_W - WSH
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_n,
    input  logic              irdy_n,
    input  logic              idsel,
    input  logic [ADDR_W-1:0] ad,
    input  logic [BE_W-1:0]   cbe_n,
    output logic              devsel_n,
    output logic              trdy_n,
    output logic              stop_n,
    output logic              bk_we,
    output logic              bk_re,
    output logic [BE_W-1:0]   bk_be,
    output logic [WA_W-1:0]   bk_addr,
    output logic              bk_adv,
    output logic [2:0]        bk_space
);

    state_e st_q, st_d;
    claim_t claim_q, dec;
    logic   start, phase_done, load;

    pci_flt_decode #(
        .ADDR_W(ADDR_W), .BE_W(BE_W),
        .SDRAM_BASE(SDRAM_BASE), .SDRAM_LG(SDRAM_LG),
        .MMIO_BASE(MMIO_BASE), .MMIO_LG(MMIO_LG),
        .IO_BASE(IO_BASE), .IO_LG(IO_LG)
    ) i_decode (
        .ad    (ad),
        .cmd   (cbe_n),
        .idsel (idsel),
        .claim (dec)
    );

    assign start      = !frame_n && irdy_n;
    assign load       = (st_q == ST_IDLE) && start;
    assign phase_done = (st_q == ST_DATA) && !irdy_n;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q    <= ST_IDLE;
            claim_q <= CLAIM_NONE;
        end else begin
            st_q <= st_d;
            if (load) claim_q <= dec;
        end
    end

    // transitions
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (start) st_d = (dec.space == SP_NONE) ? ST_SKIP : ST_DATA;
            ST_DATA: if (phase_done) begin
                if (frame_n)             st_d = ST_TURN;
                else if (claim_q.single) st_d = ST_DISC;
                else                     st_d = ST_DATA;
            end
            ST_DISC: if (frame_n) st_d = ST_TURN;
            ST_SKIP: if (frame_n && irdy_n) st_d = ST_IDLE;
            ST_TURN: st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        devsel_n = 1'b1;
        trdy_n   = 1'b1;
        stop_n   = 1'b1;
        bk_we    = 1'b0;
        bk_re    = 1'b0;
        bk_adv   = 1'b0;
        unique case (st_q)
            ST_DATA: begin
                devsel_n = 1'b0;
                trdy_n   = 1'b0;
                stop_n   = !claim_q.single;
                bk_we    = phase_done && claim_q.write;
                bk_re    = phase_done && !claim_q.write;
                bk_adv   = phase_done && !frame_n && !claim_q.single;
            end
            ST_DISC: begin
                devsel_n = 1'b0;
                stop_n   = 1'b0;
            end
            default: ;
        endcase
    end

    pci_flt_addr #(.WA_W(WA_W)) i_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (ad[ADDR_W-1:WSH]),
        .adv      (bk_adv),
        .q        (bk_addr)
    );

    pci_flt_lanes #(.BE_W(BE_W)) i_lanes (
        .space  (claim_q.space),
        .active (phase_done),
        .cbe_n  (cbe_n),
        .be     (bk_be)
    );

    assign bk_space = claim_q.space;

endmodule

// File: rtl/pci_flt_checker.sv
module pci_flt_checker #(
    parameter int WA_W = 30,
    parameter int BE_W = 4
) (
    input logic            clk,
    input logic            rst_n,
    input logic            frame_n,
    input logic            irdy_n,
    input logic [BE_W-1:0] cbe_n,
    input logic            devsel_n,
    input logic            trdy_n,
    input logic            stop_n,
    input logic            bk_we,
    input logic            bk_re,
    input logic [BE_W-1:0] bk_be,
    input logic [WA_W-1:0] bk_addr,
    input logic            bk_adv,
    input logic [2:0]      bk_space
);

    AST_TRDY_UNDER_DEVSEL: assert property (@(posedge clk) disable iff (!rst_n)
        !trdy_n |-> !devsel_n); // R1

    AST_DISC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!stop_n && !trdy_n && !irdy_n && !frame_n) |=> (trdy_n && !stop_n && !devsel_n)); // R2

    AST_CFG_IO_LANES: assert property (@(posedge clk) disable iff (!rst_n)
        ((bk_space == 3'd1 || bk_space == 3'd2) && (bk_we || bk_re)) |-> (bk_be == ~cbe_n)); // R3

    AST_WORD_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        (bk_space == 3'd3 && (bk_we || bk_re)) |-> (bk_be == '1)); // R4

    AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        bk_adv |=> (bk_addr == $past(bk_addr) + WA_W'(1))); // R5

    AST_NO_ADV_ON_STOP: assert property (@(posedge clk) disable iff (!rst_n)
        !stop_n |-> !bk_adv); // R6

    AST_STROBE_HANDSHAKE: assert property (@(posedge clk) disable iff (!rst_n)
        (bk_we || bk_re) |-> (!irdy_n && !trdy_n)); // R7

    AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        !(bk_we && bk_re)); // R7

    AST_CLAIM_HAS_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
        !devsel_n |-> (bk_space != 3'd0)); // R8

    AST_TURNAROUND: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(devsel_n) |=> (devsel_n && trdy_n && stop_n)); // R9

endmodule

bind pci_access_filter pci_flt_checker #(.WA_W(WA_W), .BE_W(BE_W)) i_chk (.*);

// File: tb/test_pci_access_filter.sv
`timescale 1ns/1ps
module test_pci_access_filter;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_n = 1'b1, irdy_n = 1'b1, idsel = 1'b0;
    logic [31:0] ad = '0;
    logic [3:0]  cbe_n = 4'hF;
    logic        devsel_n, trdy_n, stop_n, bk_we, bk_re, bk_adv;
    logic [3:0]  bk_be;
    logic [29:0] bk_addr;
    logic [2:0]  bk_space;

    int checks = 0, errors = 0, strobes = 0;
    bit reported = 0;

    always #2.5 clk = ~clk;

    pci_access_filter i_pci_access_filter (.*);

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        end
        $finish;
    endtask

    // behavioural reference: 0 idle, 1 serving, 2 stopping, 3 ignoring, 4 releasing
    int          m_mode = 0;
    int          m_space = 0;
    bit          m_single = 0, m_write = 0;
    logic [29:0] m_addr = '0;

    function automatic int ref_space(input logic [3:0] c, input logic [31:0] a, input bit sel);
        bit mem;
        mem = (c == 4'd6) || (c == 4'd7) || (c == 4'd12) || (c == 4'd14) || (c == 4'd15);
        if ((c == 4'd10 || c == 4'd11) && sel && a[1:0] == 2'b00) return 1;
        if ((c == 4'd2 || c == 4'd3) && a[31:8] == 24'h00_0010) return 2;
        if (mem && a[31:16] == 16'h2000) return 3;
        if (mem && a[31:24] == 8'h10) return 4;
        return 0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mode = 0; m_space = 0; m_single = 0; m_write = 0; m_addr = '0;
        end else begin
            case (m_mode)
                0: if (!frame_n && irdy_n) begin
                    m_space  = ref_space(cbe_n, ad, idsel);
                    m_single = (m_space == 1 || m_space == 2) || (m_space >= 3 && ad[1:0] == 2'b10);
                    m_write  = cbe_n[0];
                    m_addr   = ad[31:2];
                    m_mode   = (m_space == 0) ? 3 : 1;
                end
                1: if (!irdy_n) begin
                    if (frame_n) m_mode = 4;
                    else if (m_single) m_mode = 2;
                    else m_addr = m_addr + 30'd1;
                end
                2: if (frame_n) m_mode = 4;
                3: if (frame_n && irdy_n) m_mode = 0;
                default: m_mode = 0;
            endcase
        end
    end

    always @(negedge clk) begin
        #1;
        if (!rst_n) begin
            chk("R10 devsel", devsel_n, 1); chk("R10 trdy", trdy_n, 1);
            chk("R10 stop", stop_n, 1);     chk("R10 we", bk_we, 0);
            chk("R10 re", bk_re, 0);        chk("R10 adv", bk_adv, 0);
            chk("R10 be", bk_be, 0);
        end else begin
            bit done;
            string dl, sl, bl;
            logic [3:0] eb;
            done = (m_mode == 1) && !irdy_n;
            dl = (m_mode == 3) ? "R8 devsel" : (m_mode == 4) ? "R9 devsel" : "R1 devsel";
            sl = (m_single && m_space >= 3) ? "R6 stop" : "R2 stop";
            bl = (m_space == 3) ? "R4 be" : (m_space == 4) ? "R11 be" : "R3 be";
            eb = !done ? 4'h0 : (m_space == 3) ? 4'hF : ~cbe_n;
            chk(dl, devsel_n, !(m_mode == 1 || m_mode == 2));
            chk("R1 trdy", trdy_n, !(m_mode == 1));
            chk(sl, stop_n, !((m_mode == 1 && m_single) || m_mode == 2));
            chk("R7 we", bk_we, done && m_write);
            chk("R7 re", bk_re, done && !m_write);
            chk(bl, bk_be, eb);
            chk("R5 adv", bk_adv, done && !frame_n && !m_single);
            if (m_mode == 1) begin
                chk("R5 addr", bk_addr, m_addr);
                chk("R1 space", bk_space, m_space);
            end
            if (bk_we || bk_re) strobes++;
        end
    end

    // initiator side
    task automatic txn(input logic [3:0] cmd, input logic [31:0] addr, input bit sel,
                       input int n, input int ws_at);
        int left = n;
        int ph = 0;
        bit waited = 0;
        @(negedge clk);
        frame_n = 0; irdy_n = 1; ad = addr; cbe_n = cmd; idsel = sel;
        for (int guard = 0; guard < 200; guard++) begin
            @(negedge clk);
            idsel = 0; ad = $urandom;
            cbe_n = 4'((ph * 7 + 5) & 15);
            frame_n = (left == 1);
            if (ph == ws_at && !waited) begin irdy_n = 1; waited = 1; end
            else irdy_n = 0;
            #1;
            if (!irdy_n && !trdy_n) begin left--; ph++; end
            if (left == 0) break;
            if (!stop_n) begin
                @(negedge clk); frame_n = 1; irdy_n = 0;
                break;
            end
        end
        @(negedge clk); frame_n = 1; irdy_n = 1;
    endtask

    task automatic miss(input logic [3:0] cmd, input logic [31:0] addr, input bit sel);
        @(negedge clk);
        frame_n = 0; irdy_n = 1; ad = addr; cbe_n = cmd; idsel = sel;
        for (int k = 0; k < 4; k++) begin
            @(negedge clk); idsel = 0; irdy_n = 0; cbe_n = 4'h0;
            #1 chk("R8 unclaimed devsel", devsel_n, 1);
        end
        @(negedge clk); frame_n = 1;
        @(negedge clk); irdy_n = 1;
    endtask

    initial begin
        #(5.0 * 100000);
        errors++;
        $display("FAIL watchdog: actual running expected finished");
        report();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1;
        // config write, single phase (R3)
        strobes = 0; txn(4'b1011, 32'h0000_0010, 1, 1, -1); chk("R3 cfg strobes", strobes, 1);
        // config write trying three phases: disconnect (R2)
        strobes = 0; txn(4'b1011, 32'h0000_0020, 1, 3, -1); chk("R2 cfg strobes", strobes, 1);
        // I/O write trying two phases, I/O read
        strobes = 0; txn(4'b0011, 32'h0000_1004, 0, 2, -1); chk("R2 io strobes", strobes, 1);
        strobes = 0; txn(4'b0010, 32'h0000_10FC, 0, 1, -1); chk("R3 io strobes", strobes, 1);
        // register window write and read (R4)
        strobes = 0; txn(4'b0111, 32'h2000_0040, 0, 1, -1); chk("R4 mmio strobes", strobes, 1);
        strobes = 0; txn(4'b0110, 32'h2000_0100, 0, 3, 1);  chk("R4 mmio burst", strobes, 3);
        // SDRAM bursts (R5, R11)
        strobes = 0; txn(4'b0111, 32'h1000_0100, 0, 16, 4); chk("R5 sdram burst", strobes, 16);
        strobes = 0; txn(4'b1100, 32'h10FF_FFF0, 0, 5, -1); chk("R5 sdram read", strobes, 5);
        // wrap ordering request (R6)
        strobes = 0; txn(4'b1110, 32'h1000_0202, 0, 4, -1); chk("R6 wrap strobes", strobes, 1);
        // misses (R8)
        strobes = 0;
        miss(4'b0111, 32'h3000_0000, 0);
        miss(4'b0011, 32'h0000_5000, 0);
        miss(4'b1011, 32'h0000_0010, 0);
        miss(4'b0001, 32'h1000_0000, 0);
        chk("R8 miss strobes", strobes, 0);
        // back-to-back SDRAM bursts with turnaround (R9)
        strobes = 0;
        txn(4'b0111, 32'h1000_1000, 0, 16, -1);
        txn(4'b0111, 32'h1000_1040, 0, 16, 7);
        chk("R9 back-to-back strobes", strobes, 32);
        repeat (3) @(negedge clk);
        report();
    end

endmodule